// File: doc/BRIEF.md
# Lane Test Pattern Generator

This block sits in front of the three data lanes of a serial video link transmitter. It runs on the recovered bit clock and produces one bit per lane per cycle. In normal operation it forwards the incoming lane data. When a test mode is selected, it replaces all three data lanes with the same built-in pattern. The patterns are a 127-bit pseudo-random sequence, a slow toggle made of five zeros followed by five ones, and a fast toggle that alternates every bit. Test equipment uses them to measure bit errors and to look at the eye of each lane.

The clock lane always carries its input through untouched, whatever mode is selected. The patterns run only while an indication is present that the reference clock is inside its valid range. While that indication is absent, the patterned lanes stay idle and the pattern state is frozen.

A direct change from the fast toggle to the slow toggle is not allowed. The block refuses such a request and keeps the fast toggle running until normal mode is requested first.

Top module: `lane_pattern_gen`

## Requirements
- R1: With mode code 0 (normal) applied, each `lane_out[i]` equals `lane_in[i]` one clock later. This holds whether `ref_clk_ok` is high or low.
- R2: Mode code 1 outputs a PRBS7 sequence with feedback polynomial x^7 + x^6 + 1.
  - The 7-bit shift register is loaded with 0000001 on entry to the mode.
  - The output bit is the oldest stage, and new bit = stage7 XOR stage6.
  - The first output bit is 0, and the sequence repeats every 127 bits, 64 of which are ones.
- R3: Mode code 2 outputs the repeating slow toggle 0,0,0,0,0,1,1,1,1,1. It always restarts at its first zero whenever mode 2 is entered.
- R4: Mode code 3 outputs the repeating fast toggle 1,0,1,0,…, starting with 1 on entry.
- R5: A request for mode 2 while mode 3 is active is ignored: mode 3 keeps running. Requesting mode 0 first and then mode 2 does select the slow toggle.
- R6: While `ref_clk_ok` is low in modes 1 to 3, all data lane outputs are 0 and the pattern position is held. When it returns high, the pattern resumes from the held position.
- R7: `clk_lane_out` equals `clk_lane_in` one clock later in every mode.
- R8: In modes 1 to 3, all three data lanes carry the same bit in the same cycle.
- R9: During and after a synchronous reset, all outputs are 0 and the active mode is normal.
- R10: A mode request takes effect on the next clock edge. The output of the new mode appears one clock after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Recovered bit clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_req | input | 2 | Requested mode: 0 normal, 1 PRBS7, 2 slow toggle, 3 fast toggle |
| ref_clk_ok | input | 1 | High while the reference clock is within its valid range |
| lane_in | input | LANES | Normal data, one bit per lane |
| clk_lane_in | input | 1 | Clock lane bit |
| lane_out | output | LANES | Registered data lane bits |
| clk_lane_out | output | 1 | Registered clock lane bit |

## Verification
The assertions take for granted that `mode_req`, `ref_clk_ok` and the lane inputs are synchronous to `clk` and settled before each rising edge. The bench therefore changes every input only on the falling edge and samples the outputs at the following falling edge. The assertions also assume that reset is asserted for at least one edge before any property is evaluated; the bench holds reset for several cycles. Within those bounds, the stimulus covers every mode transition of interest, including the refused fast-to-slow step and clock-absent stretches in the middle of a pattern.

// File: rtl/lpg_pkg.sv
package lpg_pkg;
  typedef enum logic [1:0] {
    MODE_NORMAL = 2'd0,
    MODE_PRBS   = 2'd1,
    MODE_SLOW   = 2'd2,
    MODE_FAST   = 2'd3
  } lpg_mode_t;
endpackage

// File: rtl/lpg_mode_ctl.sv
module lpg_mode_ctl
  import lpg_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic [1:0] mode_req,
  output lpg_mode_t mode_q,
  output logic      enter_prbs,
  output logic      enter_slow,
  output logic      enter_fast
);
  lpg_mode_t mode_nxt;

  always_comb begin
    mode_nxt = lpg_mode_t'(mode_req);
    // fast toggle may not step straight to slow toggle
    if (mode_q == MODE_FAST && mode_nxt == MODE_SLOW)
      mode_nxt = MODE_FAST;
  end

  assign enter_prbs = (mode_nxt == MODE_PRBS) && (mode_q != MODE_PRBS);
  assign enter_slow = (mode_nxt == MODE_SLOW) && (mode_q != MODE_SLOW);
  assign enter_fast = (mode_nxt == MODE_FAST) && (mode_q != MODE_FAST);

  always_ff @(posedge clk) begin
    if (rst) mode_q <= MODE_NORMAL;
    else     mode_q <= mode_nxt;
  end

  // R5: refused fast-to-slow step keeps fast mode
  a_r5_hold_fast: assert property (@(posedge clk) disable iff (rst)
    (mode_q == MODE_FAST && mode_req == 2'd2) |=> (mode_q == MODE_FAST));
  // R10: any other request is taken at the next edge
  a_r10_take_req: assert property (@(posedge clk) disable iff (rst)
    !(mode_q == MODE_FAST && mode_req == 2'd2) |=> (mode_q == lpg_mode_t'($past(mode_req))));
endmodule

// File: rtl/lpg_prbs.sv
module lpg_prbs #(
  parameter int          WIDTH = 7,
  parameter int          TAP_A = 6,
  parameter int          TAP_B = 5,
  parameter logic [6:0]  SEED  = 7'h01
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic advance,
  output logic bit_o
);
  logic [WIDTH-1:0] sr_q;

  always_ff @(posedge clk) begin
    if (rst)          sr_q <= SEED[WIDTH-1:0];
    else if (load)    sr_q <= SEED[WIDTH-1:0];
    else if (advance) sr_q <= {sr_q[WIDTH-2:0], sr_q[TAP_A] ^ sr_q[TAP_B]};
  end

  assign bit_o = sr_q[WIDTH-1];

  // R2: register never falls into the all-zero lock-up state
  a_r2_nonzero: assert property (@(posedge clk) disable iff (rst)
    sr_q != '0);
  // R6: position frozen when not stepping
  a_r6_prbs_freeze: assert property (@(posedge clk) disable iff (rst)
    (!load && !advance) |=> $stable(sr_q));
endmodule

// File: rtl/lpg_toggle.sv
module lpg_toggle #(
  parameter int   HALF       = 5,
  parameter logic START_HIGH = 1'b0,
  localparam int  PERIOD     = 2 * HALF,
  localparam int  CW         = (PERIOD > 1) ? $clog2(PERIOD) : 1
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic advance,
  output logic bit_o
);
  logic [CW-1:0] ph_q;

  always_ff @(posedge clk) begin
    if (rst || load) ph_q <= '0;
    else if (advance) begin
      if (ph_q == CW'(PERIOD - 1)) ph_q <= '0;
      else                         ph_q <= ph_q + 1'b1;
    end
  end

  assign bit_o = START_HIGH ^ (ph_q >= CW'(HALF));

  // R3/R4: phase counter stays inside one period
  a_r3_phase_range: assert property (@(posedge clk) disable iff (rst)
    ph_q <= CW'(PERIOD - 1));
  // R3: mode entry restarts the phase
  a_r3_restart: assert property (@(posedge clk) disable iff (rst)
    load |=> (ph_q == '0));
  // R6: phase frozen when not stepping
  a_r6_tog_freeze: assert property (@(posedge clk) disable iff (rst)
    (!load && !advance) |=> $stable(ph_q));
endmodule

// File: rtl/lane_pattern_gen.sv
module lane_pattern_gen
  import lpg_pkg::*;
#(
  parameter int LANES     = 3,
  parameter int SLOW_HALF = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       mode_req,
  input  logic             ref_clk_ok,
  input  logic [LANES-1:0] lane_in,
  input  logic             clk_lane_in,
  output logic [LANES-1:0] lane_out,
  output logic             clk_lane_out
);
  lpg_mode_t mode_q;
  logic enter_prbs, enter_slow, enter_fast;
  logic prbs_bit, slow_bit, fast_bit;
  logic pat_bit;

  lpg_mode_ctl u_mode (
    .clk(clk), .rst(rst), .mode_req(mode_req), .mode_q(mode_q),
    .enter_prbs(enter_prbs), .enter_slow(enter_slow), .enter_fast(enter_fast)
  );

  lpg_prbs #(.WIDTH(7), .TAP_A(6), .TAP_B(5), .SEED(7'h01)) u_prbs (
    .clk(clk), .rst(rst), .load(enter_prbs),
    .advance(mode_q == MODE_PRBS && ref_clk_ok && !enter_prbs),
    .bit_o(prbs_bit)
  );

  lpg_toggle #(.HALF(SLOW_HALF), .START_HIGH(1'b0)) u_slow (
    .clk(clk), .rst(rst), .load(enter_slow),
    .advance(mode_q == MODE_SLOW && ref_clk_ok),
    .bit_o(slow_bit)
  );

  lpg_toggle #(.HALF(1), .START_HIGH(1'b1)) u_fast (
    .clk(clk), .rst(rst), .load(enter_fast),
    .advance(mode_q == MODE_FAST && ref_clk_ok),
    .bit_o(fast_bit)
  );

  always_comb begin
    unique case (mode_q)
      MODE_PRBS: pat_bit = prbs_bit;
      MODE_SLOW: pat_bit = slow_bit;
      MODE_FAST: pat_bit = fast_bit;
      default:   pat_bit = 1'b0;
    endcase
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst)                       lane_out[g] <= 1'b0;
      else if (mode_q == MODE_NORMAL) lane_out[g] <= lane_in[g];
      else                           lane_out[g] <= pat_bit & ref_clk_ok;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) clk_lane_out <= 1'b0;
    else     clk_lane_out <= clk_lane_in;
  end

  // R7: clock lane is a plain one-cycle copy
  a_r7_clk_lane: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (clk_lane_out == $past(clk_lane_in)));
  // R1: normal mode forwards data
  a_r1_pass: assert property (@(posedge clk) disable iff (rst)
    (mode_q == MODE_NORMAL) |=> (lane_out == $past(lane_in)));
  // R6: idle data lanes while reference clock absent in a test mode
  a_r6_idle: assert property (@(posedge clk) disable iff (rst)
    (mode_q != MODE_NORMAL && !ref_clk_ok) |=> (lane_out == '0));
  // R8: test modes drive identical bits on every lane
  a_r8_same: assert property (@(posedge clk) disable iff (rst)
    (mode_q != MODE_NORMAL) |=> (lane_out == '0 || lane_out == '1));
endmodule

// File: tb/lane_pattern_gen_bench.sv
module lane_pattern_gen_bench;
  localparam int LANES = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0] mode_req = 2'd0;
  logic ref_clk_ok = 1'b1;
  logic [LANES-1:0] lane_in = '0;
  logic clk_lane_in = 1'b0;
  logic [LANES-1:0] lane_out;
  logic clk_lane_out;

  always #2 clk = ~clk;

  lane_pattern_gen #(.LANES(LANES), .SLOW_HALF(5)) u_lane_pattern_gen (
    .clk(clk), .rst(rst), .mode_req(mode_req), .ref_clk_ok(ref_clk_ok),
    .lane_in(lane_in), .clk_lane_in(clk_lane_in),
    .lane_out(lane_out), .clk_lane_out(clk_lane_out)
  );

  int errors = 0;
  int checks = 0;
  logic seq [127];
  int m_mode = 0, m_k = 0, m_sph = 0, m_fph = 0;
  logic [LANES-1:0] exp_data;
  logic exp_clk;
  logic rec [260];
  int rec_n = 0;
  bit recording = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic string req_of(input int m);
    case (m)
      0: return "R1";
      1: return "R2";
      2: return "R3";
      default: return "R4";
    endcase
  endfunction

  // one cycle: drive on falling edge, model at rising edge, compare at next fall
  task automatic cyc(input int req, input bit ok, input logic [LANES-1:0] din, input bit ck);
    int nm;
    logic b;
    mode_req = req[1:0]; ref_clk_ok = ok; lane_in = din; clk_lane_in = ck;
    @(posedge clk);
    if (m_mode == 0) exp_data = din;
    else if (!ok) exp_data = '0;
    else begin
      case (m_mode)
        1: b = seq[m_k];
        2: b = (m_sph >= 5);
        default: b = (m_fph == 0);
      endcase
      exp_data = {LANES{b}};
    end
    exp_clk = ck;
    nm = (m_mode == 3 && req == 2) ? 3 : req;
    if (nm == 1 && m_mode != 1) m_k = 0;
    else if (m_mode == 1 && ok) m_k = (m_k + 1) % 127;
    if (nm == 2 && m_mode != 2) m_sph = 0;
    else if (m_mode == 2 && ok) m_sph = (m_sph + 1) % 10;
    if (nm == 3 && m_mode != 3) m_fph = 0;
    else if (m_mode == 3 && ok) m_fph = (m_fph + 1) % 2;
    m_mode = nm;
    @(negedge clk);
    if (m_mode != 0 && lane_out != '0 && lane_out != '1)
      check(1'b0, "R8", lane_out, exp_data);
    check(lane_out == exp_data, (!ok && exp_data == '0 && req != 0) ? "R6" : req_of(m_mode),
          lane_out, exp_data);
    check(clk_lane_out == exp_clk, "R7", clk_lane_out, exp_clk);
    if (recording && rec_n < 260) begin rec[rec_n] = lane_out[0]; rec_n++; end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    logic [6:0] s;
    int ones;
    bit per_ok;
    s = 7'h01;
    for (int i = 0; i < 127; i++) begin
      seq[i] = s[6];
      s = {s[5:0], s[6] ^ s[5]};
    end

    // R9: reset state
    mode_req = 2'd3; clk_lane_in = 1'b1; lane_in = '1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(lane_out == '0, "R9", lane_out, 0);
    check(clk_lane_out == 1'b0, "R9", clk_lane_out, 0);
    mode_req = 2'd0; clk_lane_in = 1'b0; lane_in = '0;
    @(negedge clk);
    rst = 1'b0;

    // R1: normal pass-through, all lane values, clock present and absent
    for (int i = 0; i < 24; i++)
      cyc(0, (i % 5) != 3, LANES'(i), i[0]);

    // R2 / R10: PRBS, record and check period
    cyc(1, 1'b1, '0, 1'b0);
    recording = 1;
    for (int i = 0; i < 260; i++) cyc(1, 1'b1, 3'b101, i[1]);
    recording = 0;
    per_ok = 1; ones = 0;
    for (int i = 0; i < 127; i++) begin
      if (rec[i] != rec[i+127]) per_ok = 0;
      ones += int'(rec[i]);
    end
    check(per_ok, "R2", per_ok, 1);
    check(ones == 64, "R2", ones, 64);
    check(rec[0] == 1'b0, "R2", rec[0], 0);

    // R6: clock absent mid-PRBS, then resume
    for (int i = 0; i < 6; i++) cyc(1, 1'b0, '1, 1'b1);
    for (int i = 0; i < 20; i++) cyc(1, 1'b1, '1, i[0]);

    // R3: slow toggle, exit mid-phase, re-enter restarts
    cyc(0, 1'b1, 3'b010, 1'b0);
    for (int i = 0; i < 23; i++) cyc(2, 1'b1, '1, i[0]);
    for (int i = 0; i < 4; i++) cyc(2, 1'b0, '1, 1'b0);
    for (int i = 0; i < 7; i++) cyc(2, 1'b1, '1, 1'b1);
    cyc(0, 1'b1, 3'b110, 1'b0);
    for (int i = 0; i < 22; i++) cyc(2, 1'b1, '0, i[0]);

    // R4: fast toggle straight from slow (allowed), then R5 refused step
    for (int i = 0; i < 10; i++) cyc(3, 1'b1, '0, i[0]);
    for (int i = 0; i < 8; i++) cyc(2, 1'b1, '0, i[0]);
    for (int i = 0; i < 3; i++) cyc(3, 1'b0, '1, 1'b1);
    for (int i = 0; i < 4; i++) cyc(2, 1'b1, '0, 1'b0);
    // R5: via normal mode the slow toggle is reached
    cyc(0, 1'b1, 3'b001, 1'b1);
    for (int i = 0; i < 14; i++) cyc(2, 1'b1, '0, i[0]);
    // PRBS re-entry reseeds
    for (int i = 0; i < 15; i++) cyc(1, 1'b1, '0, i[0]);
    for (int i = 0; i < 4; i++) cyc(0, 1'b1, LANES'(i), 1'b0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule